// File: doc/BRIEF.md
# USB Control Endpoint Register Bank

This block sits between a local microcontroller and a USB device's packet engine. Through a byte-wide register port the microcontroller controls endpoint 0's handshake state: stall, data loaded, and data toggle. It can also read how many bytes endpoint 0 has received, keep a flag for the direction of the control pipe, and move bytes through three data ports. Each data port is backed by a transmit FIFO and a receive FIFO for its endpoint. A register write to a data port enqueues a byte for transmission. A register read of a data port dequeues one received byte.

The packet engine delivers received bytes on a valid/ready stream tagged with an endpoint number. A byte is accepted only in a cycle where `rx_valid` and `rx_ready` are both high. `rx_ready` drops while the addressed receive FIFO is full, and it is always low for an endpoint number of 3. The engine drains each transmit FIFO through its own valid/ready lane. A byte leaves in a cycle where `tx_valid[i]` and `tx_ready[i]` are both high. The engine may hold `tx_ready` low for as long as it likes, and the byte stays at the head of the FIFO. The engine pulses `setup_seen` when a SETUP transaction arrives on endpoint 0. It pulses `ep0_acked` when the host acknowledges an endpoint 0 data packet. On each IN token it samples `ep0_reply` to choose between STALL, DATA0, DATA1 and NAK.

The register port is combinational for reads. `reg_rdata` reflects `reg_addr` in the same cycle as `reg_sel`, and the side effect of a write or a pop takes place at the clock edge that closes that cycle.

Top module: `usb_ctl_ep_regs`

## Requirements
- R1: After reset every readable register (4Dh, 4Eh, 4Fh, 50h, 51h) reads 00h, `ep0_reply` is NAK (00), and all six FIFOs report empty.
- R2: While the stall bit (bit 2 of register 4Dh) is set, `ep0_reply` is STALL (11), whatever the other two bits hold.
- R3: A `setup_seen` pulse clears the stall bit and sets the toggle bit to 1. When a register write to 4Dh falls in the same cycle, the pulse still wins for those two bits, and the ready bit takes the written value.
- R4: With stall clear and the ready bit (bit 1 of 4Dh) set, `ep0_reply` is DATA0 (01) when the toggle bit (bit 0 of 4Dh) is 0 and DATA1 (10) when it is 1. With ready clear, the reply is NAK (00).
- R5: An `ep0_acked` pulse clears the ready bit and inverts the toggle bit.
- R6: Bits 6..0 of register 4Eh count the bytes held in the endpoint 0 receive FIFO. The count rises on each accepted endpoint 0 byte and falls on each pop through 4Fh. When both happen in one cycle, the count is unchanged.
- R7: Bit 7 of 4Eh is a read/write direction flag. Writes to bits 6..0 of 4Eh are ignored.
- R8: A write to 4Fh, 50h or 51h pushes the byte into the transmit FIFO of endpoint 0, 1 or 2. Bytes leave on that endpoint's transmit lane in the order they were written.
- R9: A read of 4Fh, 50h or 51h returns the head of that endpoint's receive FIFO and pops it. Bytes come out in arrival order.
- R10: Each FIFO holds 64 bytes. A write to a full transmit FIFO is dropped, and `tx_full` is high at 64 bytes. `rx_full` is high at 64 bytes, and `rx_ready` is then low for that endpoint.
- R11: A read of a data port whose receive FIFO is empty returns 00h and changes nothing: the next byte that arrives is the next one read.
- R12: Register 4Dh reads back as {5'b0, stall, ready, toggle} with the values last written, as modified by R3 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 1 | Register access in this cycle |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, valid in the cycle of the access |
| setup_seen | input | 1 | Pulse: SETUP transaction received on endpoint 0 |
| ep0_acked | input | 1 | Pulse: host acknowledged an endpoint 0 data packet |
| ep0_reply | output | 2 | Answer to the next IN on endpoint 0: 00 NAK, 01 DATA0, 10 DATA1, 11 STALL |
| rx_valid | input | 1 | Received byte valid |
| rx_ep | input | 2 | Endpoint number of the received byte |
| rx_byte | input | 8 | Received byte |
| rx_ready | output | 1 | Addressed receive FIFO can accept the byte |
| tx_valid | output | 3 | Per endpoint: transmit byte available |
| tx_ready | input | 3 | Per endpoint: engine takes the byte |
| tx_byte | output | 24 | Per endpoint head byte, endpoint i in bits 8i+7..8i |
| tx_empty | output | 3 | Per endpoint transmit FIFO empty |
| tx_full | output | 3 | Per endpoint transmit FIFO full |
| rx_empty | output | 3 | Per endpoint receive FIFO empty |
| rx_full | output | 3 | Per endpoint receive FIFO full |

## Verification
Two pairs of functions can land in one clock cycle. In the first, a received endpoint 0 byte is accepted while the microcontroller pops 4Fh. The bench drives `rx_valid` and the register read in the same cycle, and then checks three things: the popped byte is the old head, the 4Eh count has not moved, and the new byte comes out later in order. In the second, a `setup_seen` pulse meets a register write that sets the stall bit. The bench drives both together and reads 4Dh back, and it expects stall clear, toggle set and the written ready value.

// File: rtl/usb_ep_pkg.sv
package usb_ep_pkg;
  localparam int unsigned NUM_EP   = 3;
  localparam int unsigned EP_IDX_W = 2;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CNT_W    = 7;

  localparam logic [7:0] ADDR_EP0_CTL   = 8'h4D;
  localparam logic [7:0] ADDR_EP0_RXCNT = 8'h4E;
  localparam logic [7:0] ADDR_DATA_BASE = 8'h4F;

  localparam int unsigned CTL_STALL_BIT  = 2;
  localparam int unsigned CTL_READY_BIT  = 1;
  localparam int unsigned CTL_TOGGLE_BIT = 0;
  localparam int unsigned DIR_BIT        = 7;

  typedef enum logic [1:0] {
    REPLY_NAK   = 2'b00,
    REPLY_DATA0 = 2'b01,
    REPLY_DATA1 = 2'b10,
    REPLY_STALL = 2'b11
  } ep0_reply_e;
endpackage

// File: rtl/ep_byte_fifo.sv
module ep_byte_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop_ready,
  output logic [WIDTH-1:0] pop_data,
  output logic             empty,
  output logic             full
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW:0]      wr_ptr;
  logic [AW:0]      rd_ptr;
  logic             do_push;
  logic             do_pop;

  assign empty   = (wr_ptr == rd_ptr);
  assign full    = (wr_ptr[AW] != rd_ptr[AW]) && (wr_ptr[AW-1:0] == rd_ptr[AW-1:0]);
  assign do_push = push_valid && !full;
  assign do_pop  = pop_ready && !empty;
  assign pop_data = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr[AW-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/ep0_ctl_bits.sv
module ep0_ctl_bits
  import usb_ep_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_wr,
  input  logic [2:0]    ctl_wdata,
  input  logic          dir_wr,
  input  logic          dir_wdata,
  input  logic          setup_seen,
  input  logic          tx_acked,
  input  logic          cnt_inc,
  input  logic          cnt_dec,
  output logic          stall,
  output logic          ready,
  output logic          toggle,
  output logic          dir_flag,
  output logic [CW-1:0] rx_count,
  output logic [1:0]    reply
);
  ep0_reply_e reply_q;

  // setup has priority over ack, ack over a plain write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stall  <= 1'b0;
      ready  <= 1'b0;
      toggle <= 1'b0;
    end else if (setup_seen) begin
      stall  <= 1'b0;
      toggle <= 1'b1;
      if (ctl_wr) ready <= ctl_wdata[CTL_READY_BIT];
    end else if (tx_acked) begin
      ready  <= 1'b0;
      toggle <= ~toggle;
      if (ctl_wr) stall <= ctl_wdata[CTL_STALL_BIT];
    end else if (ctl_wr) begin
      stall  <= ctl_wdata[CTL_STALL_BIT];
      ready  <= ctl_wdata[CTL_READY_BIT];
      toggle <= ctl_wdata[CTL_TOGGLE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      dir_flag <= 1'b0;
    else if (dir_wr) dir_flag <= dir_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_count <= '0;
    end else begin
      case ({cnt_inc, cnt_dec})
        2'b10:   rx_count <= rx_count + 1'b1;
        2'b01:   rx_count <= rx_count - 1'b1;
        default: rx_count <= rx_count;
      endcase
    end
  end

  always_comb begin
    if (stall)       reply_q = REPLY_STALL;
    else if (!ready) reply_q = REPLY_NAK;
    else if (toggle) reply_q = REPLY_DATA1;
    else             reply_q = REPLY_DATA0;
  end

  assign reply = reply_q;
endmodule

// File: rtl/usb_ctl_ep_regs.sv
module usb_ctl_ep_regs
  import usb_ep_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_sel,
  input  logic                       reg_wr,
  input  logic [7:0]                 reg_addr,
  input  logic [7:0]                 reg_wdata,
  output logic [7:0]                 reg_rdata,
  input  logic                       setup_seen,
  input  logic                       ep0_acked,
  output logic [1:0]                 ep0_reply,
  input  logic                       rx_valid,
  input  logic [EP_IDX_W-1:0]        rx_ep,
  input  logic [BYTE_W-1:0]          rx_byte,
  output logic                       rx_ready,
  output logic [NUM_EP-1:0]          tx_valid,
  input  logic [NUM_EP-1:0]          tx_ready,
  output logic [NUM_EP*BYTE_W-1:0]   tx_byte,
  output logic [NUM_EP-1:0]          tx_empty,
  output logic [NUM_EP-1:0]          tx_full,
  output logic [NUM_EP-1:0]          rx_empty,
  output logic [NUM_EP-1:0]          rx_full
);
  logic [NUM_EP-1:0] port_hit;
  logic [NUM_EP-1:0] tx_push;
  logic [NUM_EP-1:0] rx_pop;
  logic [NUM_EP-1:0] rx_push;
  logic [BYTE_W-1:0] rx_head [NUM_EP];

  logic              ctl_wr;
  logic              dir_wr;
  logic              stall_q;
  logic              ready_q;
  logic              toggle_q;
  logic              dir_q;
  logic [CNT_W-1:0]  rx_cnt_q;

  assign ctl_wr = reg_sel && reg_wr && (reg_addr == ADDR_EP0_CTL);
  assign dir_wr = reg_sel && reg_wr && (reg_addr == ADDR_EP0_RXCNT);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_ep
    assign port_hit[i] = reg_sel && (reg_addr == ADDR_DATA_BASE + 8'(i));
    assign tx_push[i]  = port_hit[i] && reg_wr;
    assign rx_pop[i]   = port_hit[i] && !reg_wr;
    assign rx_push[i]  = rx_valid && (rx_ep == EP_IDX_W'(i));

    ep_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (tx_push[i]),
      .push_data  (reg_wdata),
      .pop_ready  (tx_ready[i]),
      .pop_data   (tx_byte[i*BYTE_W +: BYTE_W]),
      .empty      (tx_empty[i]),
      .full       (tx_full[i])
    );

    ep_byte_fifo #(.WIDTH(BYTE_W), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_valid (rx_push[i]),
      .push_data  (rx_byte),
      .pop_ready  (rx_pop[i]),
      .pop_data   (rx_head[i]),
      .empty      (rx_empty[i]),
      .full       (rx_full[i])
    );

    assign tx_valid[i] = !tx_empty[i];
  end

  always_comb begin
    rx_ready = 1'b0;
    for (int i = 0; i < NUM_EP; i++) begin
      if (rx_ep == EP_IDX_W'(i)) rx_ready = !rx_full[i];
    end
  end

  ep0_ctl_bits #(.CW(CNT_W)) u_ep0_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_wr     (ctl_wr),
    .ctl_wdata  (reg_wdata[2:0]),
    .dir_wr     (dir_wr),
    .dir_wdata  (reg_wdata[DIR_BIT]),
    .setup_seen (setup_seen),
    .tx_acked   (ep0_acked),
    .cnt_inc    (rx_push[0] && !rx_full[0]),
    .cnt_dec    (rx_pop[0] && !rx_empty[0]),
    .stall      (stall_q),
    .ready      (ready_q),
    .toggle     (toggle_q),
    .dir_flag   (dir_q),
    .rx_count   (rx_cnt_q),
    .reply      (ep0_reply)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_sel) begin
      if (reg_addr == ADDR_EP0_CTL) begin
        reg_rdata = {5'b0, stall_q, ready_q, toggle_q};
      end else if (reg_addr == ADDR_EP0_RXCNT) begin
        reg_rdata = {dir_q, rx_cnt_q};
      end
      for (int i = 0; i < NUM_EP; i++) begin
        if (port_hit[i] && !rx_empty[i]) reg_rdata = rx_head[i];
      end
    end
  end
endmodule

// File: rtl/usb_ep_regs_chk.sv
module usb_ep_regs_chk
  import usb_ep_pkg::*;
(
  input logic                clk,
  input logic                rst_n,
  input logic                reg_sel,
  input logic                reg_wr,
  input logic [7:0]          reg_addr,
  input logic [7:0]          reg_wdata,
  input logic [7:0]          reg_rdata,
  input logic                setup_seen,
  input logic                ep0_acked,
  input logic [1:0]          ep0_reply,
  input logic                rx_valid,
  input logic [EP_IDX_W-1:0] rx_ep,
  input logic                rx_ready,
  input logic [NUM_EP-1:0]   tx_empty,
  input logic [NUM_EP-1:0]   tx_full,
  input logic [NUM_EP-1:0]   rx_empty,
  input logic [NUM_EP-1:0]   rx_full
);
  logic ctl_write;
  assign ctl_write = reg_sel && reg_wr && (reg_addr == ADDR_EP0_CTL);

  // R2
  stall_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_write && reg_wdata[CTL_STALL_BIT] && !setup_seen |=> ep0_reply == REPLY_STALL);

  // R3
  setup_unstall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_seen |=> ep0_reply != REPLY_STALL);

  // R5
  ack_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ep0_acked && !setup_seen && !ctl_write && ep0_reply != REPLY_STALL |=> ep0_reply == REPLY_NAK);

  for (genvar i = 0; i < NUM_EP; i++) begin : g_chk
    // R11
    empty_pop_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel && !reg_wr && reg_addr == ADDR_DATA_BASE + 8'(i) && rx_empty[i] |-> reg_rdata == 8'h00);

    // R10
    rx_full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && rx_ep == EP_IDX_W'(i) && rx_full[i] |-> !rx_ready);

    // R10
    tx_state_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(tx_full[i] && tx_empty[i]));
  end
endmodule

bind usb_ctl_ep_regs usb_ep_regs_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_sel    (reg_sel),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .setup_seen (setup_seen),
  .ep0_acked  (ep0_acked),
  .ep0_reply  (ep0_reply),
  .rx_valid   (rx_valid),
  .rx_ep      (rx_ep),
  .rx_ready   (rx_ready),
  .tx_empty   (tx_empty),
  .tx_full    (tx_full),
  .rx_empty   (rx_empty),
  .rx_full    (rx_full)
);

// File: tb/usb_ctl_ep_regs_tb.sv
module usb_ctl_ep_regs_tb;
  localparam int CLK_NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        setup_seen = 1'b0;
  logic        ep0_acked = 1'b0;
  logic [1:0]  ep0_reply;
  logic        rx_valid = 1'b0;
  logic [1:0]  rx_ep = '0;
  logic [7:0]  rx_byte = '0;
  logic        rx_ready;
  logic [2:0]  tx_valid;
  logic [2:0]  tx_ready = '0;
  logic [23:0] tx_byte;
  logic [2:0]  tx_empty, tx_full, rx_empty, rx_full;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] q0[$];
  logic [7:0] q1[$];
  logic [7:0] q2[$];

  always #(CLK_NS/2) clk = ~clk;

  usb_ctl_ep_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .setup_seen(setup_seen), .ep0_acked(ep0_acked), .ep0_reply(ep0_reply),
    .rx_valid(rx_valid), .rx_ep(rx_ep), .rx_byte(rx_byte), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_byte(tx_byte),
    .tx_empty(tx_empty), .tx_full(tx_full), .rx_empty(rx_empty), .rx_full(rx_full)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_sel = 0; reg_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_sel = 1; reg_wr = 0; reg_addr = a;
    #1 v = reg_rdata;
    @(posedge clk); #1;
    reg_sel = 0;
  endtask

  task automatic rx_push(input logic [1:0] ep, input logic [7:0] d, output bit acc);
    @(negedge clk);
    rx_valid = 1; rx_ep = ep; rx_byte = d;
    #1 acc = rx_ready;
    @(posedge clk); #1;
    rx_valid = 0;
  endtask

  // driver: register write to a data port, expectation queued
  task automatic tx_write(input int ep, input logic [7:0] d, input bit expect_kept);
    wr(8'h4F + 8'(ep), d);
    if (expect_kept) begin
      case (ep)
        0: q0.push_back(d);
        1: q1.push_back(d);
        default: q2.push_back(d);
      endcase
    end
  endtask

  // monitor: compare every byte taken from a transmit lane (R8)
  always @(negedge clk) begin
    #1;
    for (int i = 0; i < 3; i++) begin
      if (tx_valid[i] && tx_ready[i]) begin
        logic [7:0] e;
        int n;
        case (i)
          0: n = q0.size();
          1: n = q1.size();
          default: n = q2.size();
        endcase
        if (n == 0) begin
          check(0, "R8 unexpected tx byte", tx_byte[i*8 +: 8], 0);
        end else begin
          case (i)
            0: e = q0.pop_front();
            1: e = q1.pop_front();
            default: e = q2.pop_front();
          endcase
          check(tx_byte[i*8 +: 8] == e, "R8 tx order", tx_byte[i*8 +: 8], e);
        end
      end
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    bit acc;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    check(ep0_reply == 2'b00, "R1 reply", ep0_reply, 0);
    check(tx_empty == 3'b111 && rx_empty == 3'b111, "R1 empty", {tx_empty, rx_empty}, 6'h3f);
    rd(8'h4D, v); check(v == 8'h00, "R1 4Dh", v, 0);
    rd(8'h4E, v); check(v == 8'h00, "R1 4Eh", v, 0);
    rd(8'h50, v); check(v == 8'h00, "R1 50h", v, 0);
    rd(8'h51, v); check(v == 8'h00, "R1 51h", v, 0);

    // R4 / R12 ready with toggle 0
    wr(8'h4D, 8'h02);
    check(ep0_reply == 2'b01, "R4 DATA0", ep0_reply, 1);
    rd(8'h4D, v); check(v == 8'h02, "R12 readback", v, 2);

    // R5 ack clears ready, inverts toggle
    @(negedge clk); ep0_acked = 1; @(posedge clk); #1 ep0_acked = 0;
    check(ep0_reply == 2'b00, "R5 NAK after ack", ep0_reply, 0);
    rd(8'h4D, v); check(v == 8'h01, "R5 bits after ack", v, 1);

    wr(8'h4D, 8'h03);
    check(ep0_reply == 2'b10, "R4 DATA1", ep0_reply, 2);

    // R2 stall overrides
    wr(8'h4D, 8'h07);
    check(ep0_reply == 2'b11, "R2 STALL", ep0_reply, 3);

    // R3 setup clears stall
    @(negedge clk); setup_seen = 1; @(posedge clk); #1 setup_seen = 0;
    check(ep0_reply == 2'b10, "R3 after setup", ep0_reply, 2);
    rd(8'h4D, v); check(v == 8'h03, "R3 bits after setup", v, 3);

    // R3 setup and stall write in one cycle
    @(negedge clk);
    setup_seen = 1; reg_sel = 1; reg_wr = 1; reg_addr = 8'h4D; reg_wdata = 8'h04;
    @(posedge clk); #1;
    setup_seen = 0; reg_sel = 0; reg_wr = 0;
    rd(8'h4D, v); check(v == 8'h01, "R3 setup beats write", v, 1);
    check(ep0_reply == 2'b00, "R3 reply NAK", ep0_reply, 0);

    // R7 direction flag
    wr(8'h4E, 8'hFF);
    rd(8'h4E, v); check(v == 8'h80, "R7 dir set, count untouched", v, 8'h80);
    wr(8'h4E, 8'h00);
    rd(8'h4E, v); check(v == 8'h00, "R7 dir clear", v, 0);

    // R6 count on ep0
    rx_push(0, 8'hA1, acc); rx_push(0, 8'hA2, acc); rx_push(0, 8'hA3, acc);
    rd(8'h4E, v); check(v == 8'h03, "R6 count 3", v, 3);
    // R6 push and pop in the same cycle
    @(negedge clk);
    rx_valid = 1; rx_ep = 0; rx_byte = 8'hA4;
    reg_sel = 1; reg_wr = 0; reg_addr = 8'h4F;
    #1 v = reg_rdata;
    @(posedge clk); #1;
    rx_valid = 0; reg_sel = 0;
    check(v == 8'hA1, "R6 head on concurrent pop", v, 8'hA1);
    rd(8'h4E, v); check(v == 8'h03, "R6 count unchanged", v, 3);
    // R9 order
    rd(8'h4F, v); check(v == 8'hA2, "R9 order 2", v, 8'hA2);
    rd(8'h4F, v); check(v == 8'hA3, "R9 order 3", v, 8'hA3);
    rd(8'h4F, v); check(v == 8'hA4, "R9 order 4", v, 8'hA4);
    rd(8'h4E, v); check(v == 8'h00, "R6 count 0", v, 0);
    // R11 empty pop
    rd(8'h4F, v); check(v == 8'h00, "R11 empty pop", v, 0);
    rd(8'h4E, v); check(v == 8'h00, "R11 count kept", v, 0);
    rx_push(0, 8'hB1, acc);
    rd(8'h4F, v); check(v == 8'hB1, "R11 pointers intact", v, 8'hB1);

    // R9 endpoint 1
    rx_push(1, 8'h11, acc); rx_push(1, 8'h22, acc);
    rd(8'h50, v); check(v == 8'h11, "R9 ep1 first", v, 8'h11);
    rd(8'h50, v); check(v == 8'h22, "R9 ep1 second", v, 8'h22);

    // R10 receive full on endpoint 2
    for (int i = 0; i < 64; i++) rx_push(2, 8'(i) ^ 8'h5A, acc);
    check(rx_full[2] == 1'b1, "R10 rx_full", rx_full[2], 1);
    rx_push(2, 8'hEE, acc);
    check(acc == 1'b0, "R10 rx_ready low when full", acc, 0);
    for (int i = 0; i < 64; i++) begin
      rd(8'h51, v);
      check(v == (8'(i) ^ 8'h5A), "R10 rx drain", v, 8'(i) ^ 8'h5A);
    end
    check(rx_empty[2] == 1'b1, "R10 rx empty after drain", rx_empty[2], 1);

    // R8 / R10 transmit
    tx_write(0, 8'hC0, 1); tx_write(0, 8'hC1, 1); tx_write(0, 8'hC2, 1);
    tx_write(2, 8'hD0, 1); tx_write(2, 8'hD1, 1);
    for (int i = 0; i < 64; i++) tx_write(1, 8'(i * 3), 1);
    check(tx_full[1] == 1'b1, "R10 tx_full", tx_full[1], 1);
    tx_write(1, 8'hFF, 0);
    check(tx_full == 3'b010, "R10 only ep1 full", tx_full, 3'b010);
    @(negedge clk); tx_ready = 3'b111;
    repeat (100) @(negedge clk);
    tx_ready = 3'b000;
    check(q0.size() + q1.size() + q2.size() == 0, "R8 all bytes seen",
          q0.size() + q1.size() + q2.size(), 0);
    check(tx_empty == 3'b111, "R10 dropped byte absent", tx_empty, 3'b111);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule